// File: doc/BRIEF.md
# ATAPI Device Task-File Controller

This block is the device end of a packet-command disk interface. It holds the byte-wide task-file registers that a host writes and reads, and it steps through four states: idle, command-packet collection, PIO read-out and busy. A host starts a command by writing the packet opcode to the command register. It then pushes a 12-byte command packet through the 16-bit data port. The block gathers those bytes, drops DRQ, raises BSY and offers the packet to a separate decoder with a one-cycle strobe.

The decoder answers in one of two ways. It can signal completion with no data, or it can start a read-out with a total length in bytes. During the read-out the host pulls 16-bit words through the data port. Each word comes from an external response buffer, addressed by the word index the block drives. The host programs a block size in the byte-count registers before the command. The block interrupts at every block boundary and at the end of the transfer. While the read-out runs, the byte-count registers show the total transfer length.

Top module: `atapi_taskfile`

## Requirements
- R1: After reset, reads show error=0x01 (select 0), count=0x01 (select 1), signature=0x81 (select 2), byte-count low=0x14 (select 3), byte-count high=0xEB (select 4), device=0x00 (select 5), status=0x00 (select 6). The data port returns 0xFFFF, and intrq is low.
- R2: Writing 0xA0 to the command register (select 6) sets status to 0x58, error to the feature register (write select 0) AND 0x03, and count to 0x01 (bit 0 is command/data).
- R3: On the sixth data-port write after 0xA0, status becomes 0xD0 (BSY=bit 7 set, DRQ=bit 3 clear) and pkt_valid pulses for exactly one cycle. pkt_bytes byte k (bits 8k+7:8k) holds packet byte k, and the low byte of each word is the even byte. Before the sixth write, status stays 0x58 and pkt_valid stays low.
- R4: Data-port writes outside the command-write state change neither pkt_bytes nor status.
- R5: In the busy state, rsp_start sets status to 0x48 and count to 0x02 (bit 1 is I/O). Byte-count low and high are loaded with rsp_len[7:0] and rsp_len[15:8]. The block size is taken from the byte-count registers as they stood just before rsp_start.
- R6: In the PIO read state, dat_rdata equals buf_data, and buf_addr is the number of words already read. Each dat_rd advances by one word (two bytes).
- R7: A block counter starts at the block size and drops by 2 on each read. When it reaches zero or below before the end of the transfer, it reloads and intrq rises.
- R8: The read that brings the byte offset to at least rsp_len returns to idle, clears DRQ and raises intrq.
- R9: A data-port read outside the PIO read state returns 0xFFFF.
- R10: Every command-register write clears the pending interrupt, sets DRDY (bit 6) and SERV (bit 4) and clears CHK (bit 0). An unknown opcode changes nothing else.
- R11: Command 0x08 restores every R1 register value and sets status to 0x50.
- R12: intrq is the pending interrupt masked by control bit 1 (select 7). Setting the mask hides intrq, and clearing it shows intrq again.
- R13: In the busy state, cmd_done clears BSY and CHK, returns to idle and raises intrq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Task-file register write strobe |
| reg_sel | input | 3 | Register select for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel |
| dat_wr | input | 1 | Data-port write strobe |
| dat_wdata | input | 16 | Data-port write word |
| dat_rd | input | 1 | Data-port read strobe (advances the read-out) |
| dat_rdata | output | 16 | Data-port read word |
| pkt_valid | output | 1 | One-cycle strobe: command packet complete |
| pkt_bytes | output | 96 | Collected command packet |
| rsp_start | input | 1 | Decoder starts a PIO read-out |
| rsp_len | input | 16 | Total read-out length in bytes (non-zero) |
| cmd_done | input | 1 | Decoder finishes a command without data |
| buf_addr | output | 15 | Word index into the response buffer |
| buf_data | input | 16 | Response buffer word at buf_addr |
| intrq | output | 1 | Interrupt request to the host |

## Verification
Assertions check several rules on every cycle. DRQ must match the command-write and read-out states, and BSY must match the busy state. The packet strobe lasts one cycle, and a command write always leaves the interrupt cleared. A completed read-out lands in idle with DRQ low. The bench scenarios cover what no single-cycle property can express. They sweep transfer lengths against block sizes and check the exact read where each boundary interrupt must appear, along with the word order from the response buffer. They also check the little-endian packet byte layout, the reset signature, and that stray data writes leave no trace.

// File: rtl/atapi_tf_pkg.sv
package atapi_tf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMDW = 2'd1,
        ST_PIO  = 2'd2,
        ST_BUSY = 2'd3
    } tf_state_e;

    typedef enum logic [2:0] {
        SEL_ERRFEAT = 3'd0,
        SEL_COUNT   = 3'd1,
        SEL_SIG     = 3'd2,
        SEL_BCLO    = 3'd3,
        SEL_BCHI    = 3'd4,
        SEL_DEV     = 3'd5,
        SEL_STATCMD = 3'd6,
        SEL_CTRL    = 3'd7
    } tf_sel_e;

    localparam int BIT_BSY  = 7;
    localparam int BIT_DRDY = 6;
    localparam int BIT_SERV = 4;
    localparam int BIT_DRQ  = 3;
    localparam int BIT_CHK  = 0;
    localparam int BIT_NIEN = 1;

    localparam logic [7:0] CMD_PACKET    = 8'hA0;
    localparam logic [7:0] CMD_DEV_RESET = 8'h08;
    localparam logic [7:0] CNT_CD        = 8'h01;
    localparam logic [7:0] CNT_IO        = 8'h02;

    typedef struct packed {
        logic [7:0] error;
        logic [7:0] feature;
        logic [7:0] count;
        logic [7:0] sig;
        logic [7:0] bclo;
        logic [7:0] bchi;
        logic [7:0] device;
        logic [7:0] status;
        logic [7:0] control;
    } tf_regs_t;

    function automatic tf_regs_t tf_reset_value();
        tf_regs_t r;
        r.error   = 8'h01;
        r.feature = 8'h00;
        r.count   = 8'h01;
        r.sig     = 8'h81;
        r.bclo    = 8'h14;
        r.bchi    = 8'hEB;
        r.device  = 8'h00;
        r.status  = 8'h00;
        r.control = 8'h00;
        return r;
    endfunction

    function automatic logic [7:0] status_after_cmd(input logic [7:0] s);
        logic [7:0] t;
        t = s;
        t[BIT_DRDY] = 1'b1;
        t[BIT_SERV] = 1'b1;
        t[BIT_CHK]  = 1'b0;
        return t;
    endfunction

    function automatic logic [7:0] bits2(input int a, input int b);
        logic [7:0] t;
        t = 8'h00;
        t[a] = 1'b1;
        t[b] = 1'b1;
        return t;
    endfunction

endpackage

// File: rtl/atapi_pkt_collect.sv
module atapi_pkt_collect #(
    parameter int PKT_BYTES = 12,
    parameter int WORD_W    = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   wr_en,
    input  logic [WORD_W-1:0]      wdata,
    output logic                   last,
    output logic [PKT_BYTES*8-1:0] bytes
);
    localparam int BPW   = WORD_W / 8;
    localparam int WORDS = PKT_BYTES / BPW;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);

    logic [IDX_W-1:0] idx;

    assign last = wr_en && (idx == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
        end else if (wr_en) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (idx == IDX_W'(gi))) begin
                q <= wdata;
            end
        end
        assign bytes[gi*WORD_W +: WORD_W] = q;
    end

    // R3: the word index never runs past the last packet word
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        idx <= IDX_LAST);

endmodule

// File: rtl/atapi_pio_stream.sv
module atapi_pio_stream #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] blk_size,
    input  logic             step,
    output logic [LEN_W-2:0] word_idx,
    output logic             done_evt,
    output logic             blk_evt
);
    localparam int CNT_W = LEN_W + 1;

    logic [LEN_W-1:0]        offset;
    logic [LEN_W-1:0]        total;
    logic [LEN_W-1:0]        bsz;
    logic signed [CNT_W-1:0] left;
    logic [CNT_W-1:0]        nxt_off;
    logic signed [CNT_W-1:0] nxt_left;

    always_comb begin
        nxt_off  = {1'b0, offset} + CNT_W'(2);
        nxt_left = left - CNT_W'(2);
        done_evt = step && (nxt_off >= {1'b0, total});
        blk_evt  = step && !done_evt && (nxt_left <= 0);
    end

    assign word_idx = offset[LEN_W-1:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= '0;
            total  <= '0;
            bsz    <= '0;
            left   <= '0;
        end else if (load) begin
            offset <= '0;
            total  <= len;
            bsz    <= blk_size;
            left   <= $signed({1'b0, blk_size});
        end else if (step) begin
            offset <= nxt_off[LEN_W-1:0];
            left   <= blk_evt ? $signed({1'b0, bsz}) : nxt_left;
        end
    end

    // R7: a block boundary reloads the counter from the block size
    p_block_reload_r7: assert property (@(posedge clk) disable iff (rst)
        blk_evt |=> (left == $signed({1'b0, bsz})));

    // R6: each read moves the word index forward by exactly one
    p_word_step_r6: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (word_idx == $past(word_idx) + 1'b1));

endmodule

// File: rtl/atapi_irq.sv
module atapi_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic mask,
    output logic pend,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend <= 1'b0;
        end else if (set) begin
            pend <= 1'b1;
        end
    end

    assign irq = pend && !mask;

    // R10: a command write always leaves nothing pending
    p_clr_wins_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pend);

    // R7: a raised event is held until cleared
    p_set_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (set && !clr) |=> pend);

endmodule

// File: rtl/atapi_taskfile.sv
module atapi_taskfile
    import atapi_tf_pkg::*;
#(
    parameter int PKT_BYTES = 12,
    parameter int WORD_W    = 16,
    parameter int LEN_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr,
    input  logic [2:0]             reg_sel,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    input  logic                   dat_wr,
    input  logic [WORD_W-1:0]      dat_wdata,
    input  logic                   dat_rd,
    output logic [WORD_W-1:0]      dat_rdata,
    output logic                   pkt_valid,
    output logic [PKT_BYTES*8-1:0] pkt_bytes,
    input  logic                   rsp_start,
    input  logic [LEN_W-1:0]       rsp_len,
    input  logic                   cmd_done,
    output logic [LEN_W-2:0]       buf_addr,
    input  logic [WORD_W-1:0]      buf_data,
    output logic                   intrq
);
    tf_regs_t  regs;
    tf_state_e state;

    logic cmd_wr, acc_wr, acc_rd, acc_rsp, acc_done;
    logic pkt_last, done_evt, blk_evt, irq_pend;
    logic is_packet, is_devrst;

    // Strobe arbitration: register write first, then data write, data read, decoder
    always_comb begin
        cmd_wr    = reg_wr && (tf_sel_e'(reg_sel) == SEL_STATCMD);
        is_packet = cmd_wr && (reg_wdata == CMD_PACKET);
        is_devrst = cmd_wr && (reg_wdata == CMD_DEV_RESET);
        acc_wr    = !reg_wr && dat_wr && (state == ST_CMDW);
        acc_rd    = !reg_wr && !dat_wr && dat_rd && (state == ST_PIO);
        acc_rsp   = !reg_wr && !dat_wr && !dat_rd && (state == ST_BUSY) && rsp_start;
        acc_done  = !reg_wr && !dat_wr && !dat_rd && (state == ST_BUSY) && !rsp_start && cmd_done;
    end

    atapi_pkt_collect #(.PKT_BYTES(PKT_BYTES), .WORD_W(WORD_W)) u_pkt (
        .clk   (clk),
        .rst   (rst),
        .clear (is_packet),
        .wr_en (acc_wr),
        .wdata (dat_wdata),
        .last  (pkt_last),
        .bytes (pkt_bytes)
    );

    atapi_pio_stream #(.LEN_W(LEN_W)) u_pio (
        .clk      (clk),
        .rst      (rst),
        .load     (acc_rsp),
        .len      (rsp_len),
        .blk_size (LEN_W'({regs.bchi, regs.bclo})),
        .step     (acc_rd),
        .word_idx (buf_addr),
        .done_evt (done_evt),
        .blk_evt  (blk_evt)
    );

    atapi_irq u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (done_evt || blk_evt || acc_done),
        .clr  (cmd_wr),
        .mask (regs.control[BIT_NIEN]),
        .pend (irq_pend),
        .irq  (intrq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            regs      <= tf_reset_value();
            state     <= ST_IDLE;
            pkt_valid <= 1'b0;
        end else begin
            pkt_valid <= 1'b0;
            if (reg_wr) begin
                unique case (tf_sel_e'(reg_sel))
                    SEL_ERRFEAT: regs.feature <= reg_wdata;
                    SEL_COUNT:   regs.count   <= reg_wdata;
                    SEL_SIG:     regs.sig     <= reg_wdata;
                    SEL_BCLO:    regs.bclo    <= reg_wdata;
                    SEL_BCHI:    regs.bchi    <= reg_wdata;
                    SEL_DEV:     regs.device  <= reg_wdata;
                    SEL_CTRL:    regs.control <= reg_wdata;
                    SEL_STATCMD: begin
                        if (is_devrst) begin
                            regs         <= tf_reset_value();
                            regs.control <= regs.control;
                            regs.status  <= status_after_cmd(8'h00);
                            state        <= ST_IDLE;
                        end else if (is_packet) begin
                            regs.status <= status_after_cmd(bits2(BIT_DRDY, BIT_DRQ));
                            regs.error  <= regs.feature & 8'h03;
                            regs.count  <= CNT_CD;
                            state       <= ST_CMDW;
                        end else begin
                            regs.status <= status_after_cmd(regs.status);
                        end
                    end
                    default: ;
                endcase
            end else if (acc_wr) begin
                if (pkt_last) begin
                    regs.status[BIT_DRQ] <= 1'b0;
                    regs.status[BIT_BSY] <= 1'b1;
                    state                <= ST_BUSY;
                    pkt_valid            <= 1'b1;
                end
            end else if (acc_rd) begin
                if (done_evt) begin
                    regs.status[BIT_DRQ] <= 1'b0;
                    state                <= ST_IDLE;
                end
            end else if (acc_rsp) begin
                regs.status <= bits2(BIT_DRDY, BIT_DRQ);
                regs.count  <= CNT_IO;
                regs.bclo   <= rsp_len[7:0];
                regs.bchi   <= rsp_len[15:8];
                state       <= ST_PIO;
            end else if (acc_done) begin
                regs.status[BIT_BSY] <= 1'b0;
                regs.status[BIT_CHK] <= 1'b0;
                state                <= ST_IDLE;
            end
        end
    end

    always_comb begin
        unique case (tf_sel_e'(reg_sel))
            SEL_ERRFEAT: reg_rdata = regs.error;
            SEL_COUNT:   reg_rdata = regs.count;
            SEL_SIG:     reg_rdata = regs.sig;
            SEL_BCLO:    reg_rdata = regs.bclo;
            SEL_BCHI:    reg_rdata = regs.bchi;
            SEL_DEV:     reg_rdata = regs.device;
            SEL_STATCMD: reg_rdata = regs.status;
            SEL_CTRL:    reg_rdata = regs.control;
            default:     reg_rdata = 8'h00;
        endcase
    end

    assign dat_rdata = (state == ST_PIO) ? buf_data : {WORD_W{1'b1}};

    // R5: DRQ is set exactly in the two data-moving states
    p_drq_state_r5: assert property (@(posedge clk) disable iff (rst)
        regs.status[BIT_DRQ] == ((state == ST_CMDW) || (state == ST_PIO)));

    // R3: BSY is set exactly while the decoder owns the command
    p_bsy_state_r3: assert property (@(posedge clk) disable iff (rst)
        regs.status[BIT_BSY] == (state == ST_BUSY));

    // R3: the packet strobe lasts a single cycle
    p_pkt_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> !pkt_valid);

    // R8: the final read lands in idle with DRQ low and an interrupt pending
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> (state == ST_IDLE) && !regs.status[BIT_DRQ] && irq_pend);

    // R13: decoder completion returns to idle with BSY clear
    p_cmd_done_r13: assert property (@(posedge clk) disable iff (rst)
        acc_done |=> (state == ST_IDLE) && !regs.status[BIT_BSY] && irq_pend);

endmodule

// File: tb/tb_atapi_taskfile.sv
module tb_atapi_taskfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [2:0]  reg_sel;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        dat_wr;
    logic [15:0] dat_wdata;
    logic        dat_rd;
    logic [15:0] dat_rdata;
    logic        pkt_valid;
    logic [95:0] pkt_bytes;
    logic        rsp_start;
    logic [15:0] rsp_len;
    logic        cmd_done;
    logic [14:0] buf_addr;
    logic [15:0] buf_data;
    logic        intrq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] pat(input logic [14:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
    endfunction

    assign buf_data = pat(buf_addr);

    atapi_taskfile dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .dat_rdata(dat_rdata),
        .pkt_valid(pkt_valid), .pkt_bytes(pkt_bytes),
        .rsp_start(rsp_start), .rsp_len(rsp_len), .cmd_done(cmd_done),
        .buf_addr(buf_addr), .buf_data(buf_data), .intrq(intrq)
    );

    task automatic check(input logic [95:0] act, input logic [95:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [2:0] sel, input logic [7:0] exp, input string req);
        reg_sel = sel;
        #1;
        check(96'(reg_rdata), 96'(exp), req);
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [7:0] val);
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_dat(input logic [15:0] w);
        dat_wdata = w; dat_wr = 1'b1;
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic rd_dat();
        dat_rd = 1'b1;
        @(negedge clk);
        dat_rd = 1'b0;
    endtask

    task automatic send_packet();
        wr_reg(3'd6, 8'hA0);
        for (int i = 0; i < 6; i++) wr_dat(16'(i * 257));
    endtask

    task automatic run_read(input int bs, input int len, input bit mask_test);
        int bl;
        bit done;
        bit blk;
        wr_reg(3'd3, bs[7:0]);
        wr_reg(3'd4, bs[15:8]);
        send_packet();
        rsp_len = 16'(len); rsp_start = 1'b1;
        @(negedge clk);
        rsp_start = 1'b0;
        rd_reg(3'd6, 8'h48, "R5 status");
        rd_reg(3'd1, 8'h02, "R5 count");
        rd_reg(3'd3, len[7:0], "R5 bclo");
        rd_reg(3'd4, len[15:8], "R5 bchi");
        bl = bs;
        for (int k = 1; k <= (len + 1) / 2; k++) begin
            check(96'(dat_rdata), 96'(pat(15'(k - 1))), "R6 word");
            rd_dat();
            bl -= 2;
            done = (2 * k >= len);
            blk = !done && (bl <= 0);
            if (blk) bl = bs;
            check(96'(intrq), 96'(done || blk), done ? "R8 end irq" : "R7 block irq");
            if (blk) wr_reg(3'd6, 8'h00);
        end
        reg_sel = 3'd6; #1;
        check(96'(reg_rdata & 8'hEF), 96'h40, "R8 status idle");
        check(96'(dat_rdata), 96'hFFFF, "R9 idle read");
        if (mask_test) begin
            wr_reg(3'd7, 8'h02);
            check(96'(intrq), 96'h0, "R12 masked");
            wr_reg(3'd7, 8'h00);
            check(96'(intrq), 96'h1, "R12 unmasked");
        end
        wr_reg(3'd6, 8'h00);
        check(96'(intrq), 96'h0, "R10 clear");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [95:0] exp_pkt;
        logic [95:0] saved;
        rst = 1'b1; reg_wr = 0; reg_sel = 0; reg_wdata = 0; dat_wr = 0; dat_wdata = 0;
        dat_rd = 0; rsp_start = 0; rsp_len = 0; cmd_done = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_reg(3'd0, 8'h01, "R1 error");
        rd_reg(3'd1, 8'h01, "R1 count");
        rd_reg(3'd2, 8'h81, "R1 sig");
        rd_reg(3'd3, 8'h14, "R1 bclo");
        rd_reg(3'd4, 8'hEB, "R1 bchi");
        rd_reg(3'd5, 8'h00, "R1 device");
        rd_reg(3'd6, 8'h00, "R1 status");
        check(96'(dat_rdata), 96'hFFFF, "R1 data");
        check(96'(intrq), 96'h0, "R1 intrq");

        // R4 data writes in idle are ignored
        saved = pkt_bytes;
        wr_dat(16'hBEEF);
        rd_reg(3'd6, 8'h00, "R4 idle status");
        check(pkt_bytes, saved, "R4 idle packet");

        // R2 packet command
        wr_reg(3'd0, 8'h07);
        wr_reg(3'd6, 8'hA0);
        rd_reg(3'd6, 8'h58, "R2 status");
        rd_reg(3'd0, 8'h03, "R2 error");
        rd_reg(3'd1, 8'h01, "R2 count");

        // R3 packet collection
        for (int i = 0; i < 12; i++) exp_pkt[i*8 +: 8] = 8'(8'h10 + i);
        for (int i = 0; i < 6; i++) begin
            wr_dat({8'(8'h11 + 2*i), 8'(8'h10 + 2*i)});
            if (i < 5) begin
                check(96'(pkt_valid), 96'h0, "R3 early strobe");
                rd_reg(3'd6, 8'h58, "R3 early status");
            end
        end
        check(96'(pkt_valid), 96'h1, "R3 strobe");
        rd_reg(3'd6, 8'hD0, "R3 busy status");
        check(pkt_bytes, exp_pkt, "R3 bytes");
        @(negedge clk);
        check(96'(pkt_valid), 96'h0, "R3 strobe width");

        // R4 data writes in busy are ignored
        wr_dat(16'h1234);
        check(pkt_bytes, exp_pkt, "R4 busy packet");
        rd_reg(3'd6, 8'hD0, "R4 busy status");

        // R13 completion without data
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        rd_reg(3'd6, 8'h50, "R13 status");
        check(96'(intrq), 96'h1, "R13 intrq");
        check(96'(dat_rdata), 96'hFFFF, "R9 busy-done read");

        // R10 unknown command
        wr_reg(3'd6, 8'h00);
        check(96'(intrq), 96'h0, "R10 intrq");
        rd_reg(3'd6, 8'h50, "R10 status");

        // R5..R9, R12 sweep of block sizes against lengths
        run_read(2, 3, 1'b1);
        for (int b = 0; b <= 8; b += 2)
            for (int l = 1; l <= 18; l++)
                run_read(b, l, 1'b0);
        run_read(256, 261, 1'b0);

        // R4 data write during read-out does not advance it
        wr_reg(3'd3, 8'h04); wr_reg(3'd4, 8'h00);
        send_packet();
        rsp_len = 16'd8; rsp_start = 1'b1;
        @(negedge clk);
        rsp_start = 1'b0;
        rd_dat();
        wr_dat(16'h7777);
        check(96'(dat_rdata), 96'(pat(15'd1)), "R4 pio write ignored");

        // R11 device reset
        wr_reg(3'd2, 8'h33); wr_reg(3'd5, 8'hA0);
        wr_reg(3'd6, 8'h08);
        rd_reg(3'd0, 8'h01, "R11 error");
        rd_reg(3'd1, 8'h01, "R11 count");
        rd_reg(3'd2, 8'h81, "R11 sig");
        rd_reg(3'd3, 8'h14, "R11 bclo");
        rd_reg(3'd4, 8'hEB, "R11 bchi");
        rd_reg(3'd5, 8'h00, "R11 device");
        rd_reg(3'd6, 8'h50, "R11 status");
        check(96'(dat_rdata), 96'hFFFF, "R11 data");
        check(96'(intrq), 96'h0, "R11 intrq");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule